// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block produces the processor reset line for a supervisor chip. Three events assert it: power-up, a supply brownout, and a watchdog timeout. All intervals are counted in units of a prescaled timebase strobe `tick`. The supply condition arrives as a debounced, clock-synchronous comparator result. The watchdog is restarted by ordinary traffic on the two-wire I2C bus. A start condition followed by at least one SCL low and high phase and then a stop condition counts as a restart. A 2-bit code selects the watchdog period, and one value of that code switches the watchdog off.

The reset state machine has four states:
- `RS_LOW`: supply below trip. Entered from any state when `supply_ok` is low, and also on power-up.
- `RS_HOLD`: supply good, counting the hold interval. Entered from `RS_LOW` when `supply_ok` is high.
- `RS_RUN`: reset released and the watchdog running. Entered from `RS_HOLD` on the last hold tick.
- `RS_WDPULSE`: reset held after a watchdog timeout. Entered from `RS_RUN` on expiry. It goes back to `RS_RUN` on the last pulse tick.

A second state machine follows the bus:
- `BUS_IDLE` goes to `BUS_START` on a start condition.
- `BUS_START` goes to `BUS_SCL_LO` when SCL falls.
- `BUS_SCL_LO` goes to `BUS_CLOCKED` when SCL rises.
- A stop condition seen in `BUS_CLOCKED` produces a restart pulse and returns to `BUS_IDLE`.
- A stop in any other state returns to `BUS_IDLE` without a restart.
- A start seen in any state goes to `BUS_START`.
- Low supply forces `BUS_IDLE`.

The block also raises a lockout flag while the supply is low, so that the serial interface can abort traffic and refuse new transfers. A parameter selects the reset output polarity.

Top module: `sup_reset_ctrl`

## Requirements
- R1: After `rst_n` is released, reset stays asserted until `supply_ok` has been high for `HOLD_TICKS` ticks. Counting starts with the first tick sampled in the clock after the clock in which `supply_ok` was first seen high. Reset deasserts in the cycle after the clock edge that samples the last of those ticks.
- R2: While `supply_ok` is low, reset is asserted in that same cycle. Once the supply recovers, the hold count of R1 starts again from zero.
- R3: `lockout` is high exactly in the cycles where `supply_ok` is low.
- R4: With reset released, `wd_sel` selects the watchdog period: 2'b00 gives `WD_TICKS_LONG`, 2'b01 gives `WD_TICKS_MID` and 2'b10 gives `WD_TICKS_SHORT` ticks. If that many ticks pass without a restart, the watchdog expires.
- R5: `wd_sel` = 2'b11 disables the watchdog. Reset is never asserted by the watchdog, and the count is held at zero.
- R6: SCL and SDA pass through a two-flop synchronizer. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop that follows a start, an SCL fall and an SCL rise restarts the watchdog count from zero.
- R7: A start followed directly by a stop, with no SCL low/high phase between them, does not restart the watchdog.
- R8: On expiry, reset is asserted for `WDRST_TICKS` ticks and then released. The watchdog then counts again from zero.
- R9: Low supply aborts a bus sequence in progress. A stop that arrives after recovery without a new start does not restart the watchdog.
- R10: With `RST_ACTIVE_LOW` = 1, `rst_out` is 0 when asserted. With `RST_ACTIVE_LOW` = 0, it is 1 when asserted.
- R11: The watchdog does not count while reset is asserted, whether in power-up hold, brownout or the watchdog pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on clear, active low |
| tick | input | 1 | Prescaled timebase strobe, one cycle wide |
| supply_ok | input | 1 | Debounced supply-above-trip indication |
| scl_in | input | 1 | Sampled serial clock line |
| sda_in | input | 1 | Sampled serial data line |
| wd_sel | input | 2 | Watchdog period code |
| rst_out | output | 1 | Processor reset, polarity set by `RST_ACTIVE_LOW` |
| lockout | output | 1 | Low-supply flag for the serial interface |

## Verification
A wrong reset state shows at `rst_out` as soon as the clock after the faulty transition. This covers an early or late release, a missing pulse, and a pulse of the wrong length. A wrong watchdog count shows at `rst_out` only when the period ends, up to one full period later. For that reason the bench compares against a model on every clock, across each period code and across restart patterns, including incomplete ones. A bus tracker that accepts an incomplete sequence, or keeps its state through a brownout, shows as a missing timeout one period later.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        RS_LOW     = 2'd0,
        RS_HOLD    = 2'd1,
        RS_RUN     = 2'd2,
        RS_WDPULSE = 2'd3
    } rst_state_t;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_START   = 2'd1,
        BUS_SCL_LO  = 2'd2,
        BUS_CLOCKED = 2'd3
    } bus_state_t;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_code_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_bus_watch.sv
module sup_bus_watch
    import sup_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic abort,
    output logic kick
);

    logic [SYNC_STAGES-1:0] scl_sr;
    logic [SYNC_STAGES-1:0] sda_sr;
    logic                   scl_p;
    logic                   sda_p;
    logic                   scl_s;
    logic                   sda_s;
    bus_state_t             bus_q;
    bus_state_t             bus_d;
    logic                   start_c;
    logic                   stop_c;
    logic                   fall_c;
    logic                   rise_c;

    // Synchronizer chain; lines idle high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
            scl_p  <= scl_s;
            sda_p  <= sda_s;
        end
    end

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];

    always_comb begin
        start_c = scl_s & scl_p &  sda_p & ~sda_s;
        stop_c  = scl_s & scl_p & ~sda_p &  sda_s;
        fall_c  = scl_p & ~scl_s;
        rise_c  = ~scl_p & scl_s;
    end

    // Next-state logic
    always_comb begin
        bus_d = bus_q;
        if (abort) begin
            bus_d = BUS_IDLE;
        end else if (start_c) begin
            bus_d = BUS_START;
        end else if (stop_c) begin
            bus_d = BUS_IDLE;
        end else begin
            unique case (bus_q)
                BUS_IDLE:    bus_d = BUS_IDLE;
                BUS_START:   if (fall_c) bus_d = BUS_SCL_LO;
                BUS_SCL_LO:  if (rise_c) bus_d = BUS_CLOCKED;
                BUS_CLOCKED: bus_d = BUS_CLOCKED;
                default:     bus_d = BUS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= BUS_IDLE;
        else        bus_q <= bus_d;
    end

    // Output process
    always_comb begin
        kick = 1'b0;
        unique case (bus_q)
            BUS_CLOCKED: kick = stop_c & ~abort;
            default:     kick = 1'b0;
        endcase
    end

    // R6
    kick_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (bus_q == BUS_IDLE));

    // R9
    abort_clears_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (bus_q == BUS_IDLE));

    // R7
    kick_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_q == BUS_START) |-> !kick);

endmodule

// File: rtl/sup_wdog_count.sv
module sup_wdog_count
    import sup_pkg::*;
#(
    parameter int WD_TICKS_LONG  = 1400,
    parameter int WD_TICKS_MID   = 600,
    parameter int WD_TICKS_SHORT = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run_en,
    input  logic       kick,
    input  logic [1:0] wd_sel,
    output logic       expire
);

    localparam int CW = $clog2(max2(max2(WD_TICKS_LONG, WD_TICKS_MID), WD_TICKS_SHORT) + 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(WD_TICKS_LONG - 1);
    localparam logic [CW-1:0] LAST_MID   = CW'(WD_TICKS_MID - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(WD_TICKS_SHORT - 1);

    wd_code_t        code;
    logic [CW-1:0]   lim_last;
    logic [CW-1:0]   cnt_q;
    logic            active;
    logic            at_end;

    assign code = wd_code_t'(wd_sel);

    always_comb begin
        unique case (code)
            WD_LONG:  lim_last = LAST_LONG;
            WD_MID:   lim_last = LAST_MID;
            WD_SHORT: lim_last = LAST_SHORT;
            WD_OFF:   lim_last = '0;
            default:  lim_last = '0;
        endcase
    end

    assign active = run_en & ~kick & (code != WD_OFF);
    assign at_end = (cnt_q >= lim_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    assign expire = active & tick & at_end;

    // R5
    off_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == WD_OFF) |=> (cnt_q == '0));

    // R11
    idle_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0));

    // R4
    expire_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

    // R6
    kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0));

endmodule

// File: rtl/sup_rst_fsm.sv
module sup_rst_fsm
    import sup_pkg::*;
#(
    parameter int HOLD_TICKS  = 200,
    parameter int WDRST_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic wd_expire,
    output logic rst_asserted,
    output logic wd_run,
    output logic lockout
);

    localparam int CW = $clog2(max2(HOLD_TICKS, WDRST_TICKS) + 1);
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(WDRST_TICKS - 1);

    rst_state_t    state_q;
    rst_state_t    state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Next-state and interval counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!supply_ok) begin
            state_d = RS_LOW;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                RS_LOW: begin
                    state_d = RS_HOLD;
                    cnt_d   = '0;
                end
                RS_HOLD: begin
                    if (tick) begin
                        if (cnt_q == HOLD_LAST) begin
                            state_d = RS_RUN;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                RS_RUN: begin
                    cnt_d = '0;
                    if (wd_expire) state_d = RS_WDPULSE;
                end
                RS_WDPULSE: begin
                    if (tick) begin
                        if (cnt_q == PULSE_LAST) begin
                            state_d = RS_RUN;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = RS_LOW;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output process
    always_comb begin
        lockout = ~supply_ok;
        unique case (state_q)
            RS_RUN:  begin rst_asserted = ~supply_ok; wd_run = supply_ok; end
            default: begin rst_asserted = 1'b1;       wd_run = 1'b0;      end
        endcase
    end

    // R2
    brownout_enters_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_q == RS_LOW));

    // R1
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_RUN && $past(state_q) == RS_HOLD) |-> $past(tick));

    // R8
    pulse_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_RUN && wd_expire && supply_ok) |=> (state_q == RS_WDPULSE));

    // R8
    pulse_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_WDPULSE) |-> (cnt_q <= PULSE_LAST));

    // R1
    hold_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HOLD) |-> (cnt_q <= HOLD_LAST));

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter bit RST_ACTIVE_LOW = 1'b1,
    parameter int HOLD_TICKS     = 200,
    parameter int WDRST_TICKS    = 200,
    parameter int WD_TICKS_LONG  = 1400,
    parameter int WD_TICKS_MID   = 600,
    parameter int WD_TICKS_SHORT = 200,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] wd_sel,
    output logic       rst_out,
    output logic       lockout
);

    logic kick;
    logic wd_expire;
    logic wd_run;
    logic rst_asserted;

    sup_bus_watch #(
        .SYNC_STAGES (SYNC_STAGES)
    ) bus_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .abort  (lockout),
        .kick   (kick)
    );

    sup_wdog_count #(
        .WD_TICKS_LONG  (WD_TICKS_LONG),
        .WD_TICKS_MID   (WD_TICKS_MID),
        .WD_TICKS_SHORT (WD_TICKS_SHORT)
    ) wdog_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run_en (wd_run),
        .kick   (kick),
        .wd_sel (wd_sel),
        .expire (wd_expire)
    );

    sup_rst_fsm #(
        .HOLD_TICKS  (HOLD_TICKS),
        .WDRST_TICKS (WDRST_TICKS)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .supply_ok    (supply_ok),
        .wd_expire    (wd_expire),
        .rst_asserted (rst_asserted),
        .wd_run       (wd_run),
        .lockout      (lockout)
    );

    generate
        if (RST_ACTIVE_LOW) begin : g_pol_low
            assign rst_out = ~rst_asserted;
        end else begin : g_pol_high
            assign rst_out = rst_asserted;
        end
    endgenerate

    // R2
    brownout_drives_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (rst_out == RST_ACTIVE_LOW ? 1'b0 : 1'b1));

    // R11
    no_expire_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out == (RST_ACTIVE_LOW ? 1'b0 : 1'b1)) |-> !wd_expire);

endmodule

// File: tb/sup_reset_ctrl_tb_top.sv
module sup_reset_ctrl_tb_top;

    localparam int HOLD  = 5;
    localparam int WDR   = 4;
    localparam int WLONG = 40;
    localparam int WMID  = 20;
    localparam int WSHRT = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       supply_ok = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic [1:0] wd_sel = 2'b11;
    logic       rst_lo, rst_hi, lock_lo, lock_hi;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    sup_reset_ctrl #(
        .RST_ACTIVE_LOW (1'b1), .HOLD_TICKS (HOLD), .WDRST_TICKS (WDR),
        .WD_TICKS_LONG (WLONG), .WD_TICKS_MID (WMID), .WD_TICKS_SHORT (WSHRT),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .tick (tick), .supply_ok (supply_ok),
        .scl_in (scl_in), .sda_in (sda_in), .wd_sel (wd_sel),
        .rst_out (rst_lo), .lockout (lock_lo)
    );

    sup_reset_ctrl #(
        .RST_ACTIVE_LOW (1'b0), .HOLD_TICKS (HOLD), .WDRST_TICKS (WDR),
        .WD_TICKS_LONG (WLONG), .WD_TICKS_MID (WMID), .WD_TICKS_SHORT (WSHRT),
        .SYNC_STAGES (2)
    ) dut_hi_i (
        .clk (clk), .rst_n (rst_n), .tick (tick), .supply_ok (supply_ok),
        .scl_in (scl_in), .sda_in (sda_in), .wd_sel (wd_sel),
        .rst_out (rst_hi), .lockout (lock_hi)
    );

    // Behavioural reference model
    int   m_phase;      // 0 low, 1 holding, 2 released, 3 watchdog pulse
    int   m_hold;
    int   m_wd;
    int   m_bus;        // 0 idle, 1 started, 2 scl low seen, 3 clocked
    bit   scl_hist[$];
    bit   sda_hist[$];
    int   m_pulses;

    function automatic int period_of(input logic [1:0] s);
        case (s)
            2'b00:   return WLONG;
            2'b01:   return WMID;
            2'b10:   return WSHRT;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_hold = 0; m_wd = 0; m_bus = 0;
            scl_hist = '{1'b1, 1'b1, 1'b1};
            sda_hist = '{1'b1, 1'b1, 1'b1};
        end else begin
            // hist[2] = synchronized value, hist[1]? index 0 newest
            bit s_now, s_old, d_now, d_old;
            bit st, sp, fl, rs, kick, en, exp_w;
            int per;
            s_now = scl_hist[1]; s_old = scl_hist[2];
            d_now = sda_hist[1]; d_old = sda_hist[2];
            st = s_now && s_old && d_old && !d_now;
            sp = s_now && s_old && !d_old && d_now;
            fl = s_old && !s_now;
            rs = !s_old && s_now;
            kick = 0;
            if (!supply_ok) m_bus = 0;
            else if (st) m_bus = 1;
            else if (sp) begin kick = (m_bus == 3); m_bus = 0; end
            else if (m_bus == 1 && fl) m_bus = 2;
            else if (m_bus == 2 && rs) m_bus = 3;
            scl_hist.push_front(scl_in); void'(scl_hist.pop_back());
            sda_hist.push_front(sda_in); void'(sda_hist.pop_back());

            per = period_of(wd_sel);
            en = (m_phase == 2) && supply_ok && !kick && (per != 0);
            exp_w = en && tick && (m_wd >= per - 1);
            if (!en) m_wd = 0;
            else if (tick) m_wd = (m_wd >= per - 1) ? 0 : m_wd + 1;

            if (!supply_ok) begin m_phase = 0; m_hold = 0; end
            else case (m_phase)
                0: begin m_phase = 1; m_hold = 0; end
                1: if (tick) begin
                       if (m_hold == HOLD - 1) begin m_phase = 2; m_hold = 0; end
                       else m_hold++;
                   end
                2: if (exp_w) begin m_phase = 3; m_hold = 0; m_pulses++; end
                default: if (tick) begin
                       if (m_hold == WDR - 1) begin m_phase = 2; m_hold = 0; end
                       else m_hold++;
                   end
            endcase
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            bit asserted;
            asserted = (m_phase != 2) || !supply_ok;
            check(cur_req, rst_lo, !asserted);
            check("R10", rst_hi, asserted);
            check("R3", lock_lo, !supply_ok);
        end
    end

    // Tick strobe every third clock
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_restart();
        sda_in = 1'b0; wait_clk(2);           // start
        scl_in = 1'b0; wait_clk(2);
        scl_in = 1'b1; wait_clk(2);
        scl_in = 1'b0; wait_clk(2);
        scl_in = 1'b1; wait_clk(2);
        sda_in = 1'b1; wait_clk(2);           // stop
    endtask

    task automatic bus_bare();
        sda_in = 1'b0; wait_clk(2);           // start
        sda_in = 1'b1; wait_clk(2);           // stop, no clock phase
    endtask

    initial begin
        int p0;
        wait_clk(4);
        // R1: reset state and power-up hold
        cur_req = "R1";
        check("R1", rst_lo, 1'b0);
        check("R10", rst_hi, 1'b1);
        rst_n = 1'b1;
        wait_clk(3);
        supply_ok = 1'b1;
        wait_clk(30);
        check("R1", rst_lo, 1'b1);

        // R5: disabled watchdog never fires
        cur_req = "R5";
        wd_sel = 2'b11;
        wait_clk(200);
        check("R5", rst_lo, 1'b1);

        // R4 / R8: short period expires, pulse, restart from zero
        cur_req = "R8";
        p0 = m_pulses;
        wd_sel = 2'b10;
        wait_clk(130);
        check("R4", (m_pulses - p0 >= 2) ? 1'b1 : 1'b0, 1'b1);

        // R6: regular restarts keep reset released
        cur_req = "R6";
        wd_sel = 2'b11; wait_clk(20);
        wd_sel = 2'b01;
        p0 = m_pulses;
        for (int i = 0; i < 10; i++) begin
            bus_restart();
            wait_clk(20);
        end
        check("R6", (m_pulses == p0) ? 1'b1 : 1'b0, 1'b1);

        // R7: bare start/stop does not restart
        cur_req = "R7";
        p0 = m_pulses;
        for (int i = 0; i < 20; i++) begin
            bus_bare();
            wait_clk(6);
        end
        check("R7", (m_pulses > p0) ? 1'b1 : 1'b0, 1'b1);

        // R4: long period with restarts, then left to expire
        cur_req = "R4";
        wd_sel = 2'b00;
        for (int i = 0; i < 4; i++) begin
            bus_restart();
            wait_clk(60);
        end
        p0 = m_pulses;
        wait_clk(160);
        check("R4", (m_pulses > p0) ? 1'b1 : 1'b0, 1'b1);

        // R2 / R11: brownout in run, in hold, in pulse
        cur_req = "R2";
        wd_sel = 2'b10;
        wait_clk(7);
        supply_ok = 1'b0; wait_clk(10);
        supply_ok = 1'b1; wait_clk(8);
        supply_ok = 1'b0; wait_clk(3);
        supply_ok = 1'b1;
        cur_req = "R11";
        wait_clk(80);
        supply_ok = 1'b0; wait_clk(1);
        supply_ok = 1'b1; wait_clk(40);

        // R9: sequence broken by brownout is not a restart
        cur_req = "R9";
        wd_sel = 2'b01;
        wait_clk(40);
        sda_in = 1'b0; wait_clk(2);
        scl_in = 1'b0; wait_clk(2);
        supply_ok = 1'b0;
        scl_in = 1'b1; wait_clk(3);
        supply_ok = 1'b1; wait_clk(1);
        sda_in = 1'b1; wait_clk(2);
        wait_clk(150);

        cur_req = "R10";
        wait_clk(10);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule